// File: doc/BRIEF.md
# Floating-Point Instruction Decoder with Capability Gating

This block sits in the decode stage of a processor that has an optional single-precision floating-point unit. It receives a 32-bit instruction word that earlier decode has already classified as a floating-point instruction. It also receives three capability straps and the processor's exception-enable status bit.

One clock later it produces a registered decode result: a one-hot select for the operation, a swap control that tells the arithmetic units to exchange the two operands, a compare sub-opcode, a flag that says whether the second operand is read at all, a fixed rounding-mode code, and a writeback enable. When the instruction is not allowed on the configured hardware, the block instead raises an exception request with a cause code, or it quietly cancels the instruction.

The arithmetic units, register-file access and pipeline stalls are outside this block. The block only decides what the instruction means and whether it may proceed.

Top module: `fpdec_top`

## Requirements
- R1: The operation field is instruction bits [9:7], decoded as 0 add, 1 reverse subtract, 2 multiply, 3 divide, 4 compare, 5 integer-to-float, 6 float-to-integer, 7 square root. When `wbEn` is high, `opSel` has exactly bit N set, where N is that field. When `wbEn` is low, `opSel` is zero.
- R2: `swapOps` is high for reverse subtract (field 1, result b - a) and divide (field 3, result b / a). It is low for every other issued operation and whenever `wbEn` is low.
- R3: For an issued compare (field 4), `cmpCode` equals instruction bits [6:4]. Otherwise `cmpCode` is zero.
- R4: `useOpB` is high for issued fields 0 to 4. It is low for fields 5, 6 and 7, which read operand a only, and it is low whenever `wbEn` is low.
- R5: If `capFpu` is 0, `capIllegalExc` is 1 and `msrExcEn` is 1, the block asserts `excReq` with `excCause` = 1 (illegal opcode) and does not write back.
- R6: If `capFpu` is 1, `capFpuExt` is 0, the field is 5, 6 or 7, and `msrExcEn` is 1, the block asserts `excReq` with `excCause` = 6 (floating-point) and does not write back.
- R7: An instruction that is blocked but raises no exception is cancelled: `wbEn` = 0 and `excReq` = 0. This covers base FPU absent without R5 applying, and field 5 to 7 without the extended capability while `msrExcEn` = 0. `excCause` is zero whenever `excReq` is low.
- R8: A permitted compare with sub-opcode 0 or 7 asserts `unsupported` and leaves `wbEn` and `excReq` low.
- R9: At most one of `wbEn`, `excReq` and `unsupported` is high in any cycle. A permitted instruction that matches none of R5 to R8 asserts `wbEn`.
- R10: `roundMode` is always 2'b00, the code for round-to-nearest-even.
- R11: All outputs are registered and appear in the cycle after the instruction is presented with `instValid` high. In a cycle after `instValid` was low, and after reset, every output except `roundMode` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction word is valid this cycle |
| instWord | input | 32 | Floating-point instruction word |
| capFpu | input | 1 | Base FPU present |
| capFpuExt | input | 1 | Extended FPU (conversions, square root) present |
| capIllegalExc | input | 1 | Illegal-opcode exceptions enabled |
| msrExcEn | input | 1 | Machine-status exception enable |
| opSel | output | 8 | One-hot operation select |
| swapOps | output | 1 | Exchange operands a and b |
| cmpCode | output | 3 | Compare sub-opcode |
| useOpB | output | 1 | Second operand is read |
| roundMode | output | 2 | Rounding mode code (nearest-even) |
| wbEn | output | 1 | Result writeback enable |
| excReq | output | 1 | Exception request |
| excCause | output | 5 | Exception cause code |
| unsupported | output | 1 | Compare sub-opcode not implemented |

## Verification
The bench builds the block with its default parameters: a 32-bit word, operation field at bit 7, compare field at bit 4, and cause codes 1 and 6. With these values the whole decision space fits in 1024 cases: eight operation codes, eight compare codes and all sixteen combinations of the four gating bits. The bench sweeps every case with random filler in the unused instruction bits. It interleaves cycles with `instValid` low, so that both the exception priority order and the cancellation paths are covered completely.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;

  localparam int FIELD_W = 3;
  localparam int NUM_OPS = 1 << FIELD_W;

  typedef enum logic [FIELD_W-1:0] {
    OP_ADD   = 3'd0,
    OP_RSUB  = 3'd1,
    OP_MUL   = 3'd2,
    OP_RDIV  = 3'd3,
    OP_CMP   = 3'd4,
    OP_ITOF  = 3'd5,
    OP_FTOI  = 3'd6,
    OP_SQRT  = 3'd7
  } fpOp_e;

  localparam logic [1:0] RND_NEAREST_EVEN = 2'b00;

  // Control-to-datapath strobes, mutually exclusive by construction in ctrl.
  typedef struct packed {
    logic issue;
    logic raiseIll;
    logic raiseFpu;
    logic unsup;
  } ctrlStrobes_t;

endpackage

// File: rtl/fpdec_ctrl.sv
module fpdec_ctrl
  import fpdec_pkg::*;
(
  input  logic               instValid,
  input  fpOp_e              opField,
  input  logic [FIELD_W-1:0] cmpField,
  input  logic               capFpu,
  input  logic               capFpuExt,
  input  logic               capIllegalExc,
  input  logic               msrExcEn,
  output ctrlStrobes_t       strobes
);

  logic extOp;
  logic cmpBad;

  always_comb begin
    extOp  = (opField == OP_ITOF) || (opField == OP_FTOI) || (opField == OP_SQRT);
    cmpBad = (opField == OP_CMP) &&
             ((cmpField == '0) || (cmpField == '1));
  end

  // Priority: missing base FPU, then missing extension, then bad compare.
  always_comb begin
    strobes = '0;
    if (instValid) begin
      if (!capFpu) begin
        strobes.raiseIll = capIllegalExc && msrExcEn;
      end else if (extOp && !capFpuExt) begin
        strobes.raiseFpu = msrExcEn;
      end else if (cmpBad) begin
        strobes.unsup = 1'b1;
      end else begin
        strobes.issue = 1'b1;
      end
    end
  end

endmodule

// File: rtl/fpdec_dp.sv
module fpdec_dp
  import fpdec_pkg::*;
#(
  parameter int INST_W    = 32,
  parameter int OP_LSB    = 7,
  parameter int CMP_LSB   = 4,
  parameter int CAUSE_W   = 5,
  parameter int CAUSE_ILL = 1,
  parameter int CAUSE_FPU = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INST_W-1:0]  instWord,
  output fpOp_e              opField,
  output logic [FIELD_W-1:0] cmpField,
  input  ctrlStrobes_t       strobes,
  output logic [NUM_OPS-1:0] opSel,
  output logic               swapOps,
  output logic [FIELD_W-1:0] cmpCode,
  output logic               useOpB,
  output logic [1:0]         roundMode,
  output logic               wbEn,
  output logic               excReq,
  output logic [CAUSE_W-1:0] excCause,
  output logic               unsupported
);

  localparam logic [CAUSE_W-1:0] ILL_CODE = CAUSE_W'(CAUSE_ILL);
  localparam logic [CAUSE_W-1:0] FPU_CODE = CAUSE_W'(CAUSE_FPU);

  assign opField  = fpOp_e'(instWord[OP_LSB +: FIELD_W]);
  assign cmpField = instWord[CMP_LSB +: FIELD_W];

  logic [NUM_OPS-1:0] selNext;
  logic [NUM_OPS-1:0] swapMask;
  logic [NUM_OPS-1:0] unaryMask;

  // Per-operation select and property masks.
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    assign selNext[g]   = strobes.issue && (opField == fpOp_e'(g));
    assign swapMask[g]  = (g == OP_RSUB) || (g == OP_RDIV);
    assign unaryMask[g] = (g == OP_ITOF) || (g == OP_FTOI) || (g == OP_SQRT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opSel       <= '0;
      swapOps     <= 1'b0;
      cmpCode     <= '0;
      useOpB      <= 1'b0;
      wbEn        <= 1'b0;
      excReq      <= 1'b0;
      excCause    <= '0;
      unsupported <= 1'b0;
    end else begin
      opSel       <= selNext;
      swapOps     <= |(selNext & swapMask);
      useOpB      <= |(selNext & ~unaryMask);
      cmpCode     <= selNext[OP_CMP] ? cmpField : '0;
      wbEn        <= strobes.issue;
      excReq      <= strobes.raiseIll || strobes.raiseFpu;
      excCause    <= strobes.raiseIll ? ILL_CODE :
                     strobes.raiseFpu ? FPU_CODE : '0;
      unsupported <= strobes.unsup;
    end
  end

  assign roundMode = RND_NEAREST_EVEN;

endmodule

// File: rtl/fpdec_top.sv
module fpdec_top
  import fpdec_pkg::*;
#(
  parameter int INST_W    = 32,
  parameter int OP_LSB    = 7,
  parameter int CMP_LSB   = 4,
  parameter int CAUSE_W   = 5,
  parameter int CAUSE_ILL = 1,
  parameter int CAUSE_FPU = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instValid,
  input  logic [INST_W-1:0]  instWord,
  input  logic               capFpu,
  input  logic               capFpuExt,
  input  logic               capIllegalExc,
  input  logic               msrExcEn,
  output logic [NUM_OPS-1:0] opSel,
  output logic               swapOps,
  output logic [FIELD_W-1:0] cmpCode,
  output logic               useOpB,
  output logic [1:0]         roundMode,
  output logic               wbEn,
  output logic               excReq,
  output logic [CAUSE_W-1:0] excCause,
  output logic               unsupported
);

  fpOp_e              opField;
  logic [FIELD_W-1:0] cmpField;
  ctrlStrobes_t       strobes;

  fpdec_ctrl ctrl_i (
    .instValid     (instValid),
    .opField       (opField),
    .cmpField      (cmpField),
    .capFpu        (capFpu),
    .capFpuExt     (capFpuExt),
    .capIllegalExc (capIllegalExc),
    .msrExcEn      (msrExcEn),
    .strobes       (strobes)
  );

  fpdec_dp #(
    .INST_W    (INST_W),
    .OP_LSB    (OP_LSB),
    .CMP_LSB   (CMP_LSB),
    .CAUSE_W   (CAUSE_W),
    .CAUSE_ILL (CAUSE_ILL),
    .CAUSE_FPU (CAUSE_FPU)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .instWord    (instWord),
    .opField     (opField),
    .cmpField    (cmpField),
    .strobes     (strobes),
    .opSel       (opSel),
    .swapOps     (swapOps),
    .cmpCode     (cmpCode),
    .useOpB      (useOpB),
    .roundMode   (roundMode),
    .wbEn        (wbEn),
    .excReq      (excReq),
    .excCause    (excCause),
    .unsupported (unsupported)
  );

endmodule

// File: rtl/fpdec_chk.sv
module fpdec_chk
  import fpdec_pkg::*;
#(
  parameter int INST_W    = 32,
  parameter int OP_LSB    = 7,
  parameter int CAUSE_W   = 5,
  parameter int CAUSE_ILL = 1,
  parameter int CAUSE_FPU = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               instValid,
  input logic [INST_W-1:0]  instWord,
  input logic               capFpu,
  input logic               capFpuExt,
  input logic               capIllegalExc,
  input logic               msrExcEn,
  input logic [NUM_OPS-1:0] opSel,
  input logic               swapOps,
  input logic               useOpB,
  input logic               wbEn,
  input logic               excReq,
  input logic [CAUSE_W-1:0] excCause,
  input logic               unsupported
);

  logic extField;
  assign extField = instWord[OP_LSB +: FIELD_W] >= 3'd5;

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $countones({wbEn, excReq, unsupported}) <= 1);

  a_r1_onehot_sel: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> $countones(opSel) == 1);

  a_r1_idle_sel: assert property (@(posedge clk) disable iff (!rstN)
    !wbEn |-> opSel == '0);

  a_r2_swap_ops: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> swapOps == (opSel[1] | opSel[3]));

  a_r4_unary_ops: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> useOpB == (opSel[4:0] != '0));

  a_r5_illegal_cause: assert property (@(posedge clk) disable iff (!rstN)
    instValid && !capFpu && capIllegalExc && msrExcEn
    |=> excReq && excCause == CAUSE_W'(CAUSE_ILL) && !wbEn);

  a_r6_ext_cause: assert property (@(posedge clk) disable iff (!rstN)
    instValid && capFpu && !capFpuExt && extField && msrExcEn
    |=> excReq && excCause == CAUSE_W'(CAUSE_FPU) && !wbEn);

  a_r7_quiet_cancel: assert property (@(posedge clk) disable iff (!rstN)
    instValid && !msrExcEn |=> !excReq && excCause == '0);

  a_r11_idle_cycle: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> !wbEn && !excReq && !unsupported);

endmodule

bind fpdec_top fpdec_chk #(
  .INST_W    (INST_W),
  .OP_LSB    (OP_LSB),
  .CAUSE_W   (CAUSE_W),
  .CAUSE_ILL (CAUSE_ILL),
  .CAUSE_FPU (CAUSE_FPU)
) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .instValid     (instValid),
  .instWord      (instWord),
  .capFpu        (capFpu),
  .capFpuExt     (capFpuExt),
  .capIllegalExc (capIllegalExc),
  .msrExcEn      (msrExcEn),
  .opSel         (opSel),
  .swapOps       (swapOps),
  .useOpB        (useOpB),
  .wbEn          (wbEn),
  .excReq        (excReq),
  .excCause      (excCause),
  .unsupported   (unsupported)
);

// File: tb/fpdec_top_tb_top.sv
module fpdec_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic        capFpu = 1'b0;
  logic        capFpuExt = 1'b0;
  logic        capIllegalExc = 1'b0;
  logic        msrExcEn = 1'b0;
  logic [7:0]  opSel;
  logic        swapOps;
  logic [2:0]  cmpCode;
  logic        useOpB;
  logic [1:0]  roundMode;
  logic        wbEn;
  logic        excReq;
  logic [4:0]  excCause;
  logic        unsupported;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpdec_top dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .capFpu(capFpu), .capFpuExt(capFpuExt), .capIllegalExc(capIllegalExc),
    .msrExcEn(msrExcEn), .opSel(opSel), .swapOps(swapOps), .cmpCode(cmpCode),
    .useOpB(useOpB), .roundMode(roundMode), .wbEn(wbEn), .excReq(excReq),
    .excCause(excCause), .unsupported(unsupported)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input logic [7:0] eSel, input bit eSwap, input logic [2:0] eCmp,
                          input bit eUseB, input bit eWb, input bit eExc,
                          input logic [4:0] eCause, input bit eUns);
    check(opSel == eSel, "R1 opSel", int'(opSel), int'(eSel));
    check(swapOps == eSwap, "R2 swapOps", int'(swapOps), int'(eSwap));
    check(cmpCode == eCmp, "R3 cmpCode", int'(cmpCode), int'(eCmp));
    check(useOpB == eUseB, "R4 useOpB", int'(useOpB), int'(eUseB));
    check(excCause == eCause, "R5/R6 excCause", int'(excCause), int'(eCause));
    check(excReq == eExc, "R7 excReq", int'(excReq), int'(eExc));
    check(unsupported == eUns, "R8 unsupported", int'(unsupported), int'(eUns));
    check(wbEn == eWb, "R9 wbEn", int'(wbEn), int'(eWb));
    check(roundMode == 2'b00, "R10 roundMode", int'(roundMode), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] eSel;
    logic [2:0] eCmp;
    logic [4:0] eCause;
    bit eSwap, eUseB, eWb, eExc, eUns;
    repeat (3) @(negedge clk);
    // R11: reset state
    checkAll(8'h00, 0, 3'd0, 0, 0, 0, 5'd0, 0);
    rstN = 1'b1;
    for (int cfg = 0; cfg < 16; cfg++) begin
      for (int op = 0; op < 8; op++) begin
        for (int cm = 0; cm < 8; cm++) begin
          @(negedge clk);
          {capFpu, capFpuExt, capIllegalExc, msrExcEn} = 4'(cfg);
          instWord = $urandom;
          instWord[9:7] = 3'(op);
          instWord[6:4] = 3'(cm);
          instValid = 1'b1;
          eSel = '0; eCmp = '0; eCause = '0;
          eSwap = 0; eUseB = 0; eWb = 0; eExc = 0; eUns = 0;
          if (!capFpu) begin
            if (capIllegalExc && msrExcEn) begin eExc = 1; eCause = 5'd1; end  // R5
          end else if (op >= 5 && !capFpuExt) begin
            if (msrExcEn) begin eExc = 1; eCause = 5'd6; end                   // R6, else R7
          end else if (op == 4 && (cm == 0 || cm == 7)) begin
            eUns = 1;                                                          // R8
          end else begin
            eWb = 1;                                                           // R9
            eSel = 8'(1 << op);
            eSwap = (op == 1) || (op == 3);
            eUseB = (op <= 4);
            eCmp = (op == 4) ? 3'(cm) : 3'd0;
          end
          @(negedge clk);
          checkAll(eSel, eSwap, eCmp, eUseB, eWb, eExc, eCause, eUns);
          // R11: an idle cycle after a valid one clears the outputs
          if (((op + cm) % 5) == 0) begin
            instValid = 1'b0;
            @(negedge clk);
            checkAll(8'h00, 0, 3'd0, 0, 0, 0, 5'd0, 0);
          end
        end
      end
    end
    instValid = 1'b0;
    @(negedge clk);
    checkAll(8'h00, 0, 3'd0, 0, 0, 0, 5'd0, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule